// File: doc/BRIEF.md
# Per-Bank Request Scheduler with Adaptive Auto-Precharge

This block holds the memory requests waiting for one DRAM bank and decides which one goes out next. Each request carries a row, a column and a direction (read or write). Requests enter through a valid/ready push port and leave through a valid/ready pop port. The selected request is presented combinationally with a flag that says whether its column access should also close the row (auto-precharge).

The choice depends on a static ordering mode:
- plain arrival order;
- open-row hits first, oldest first among equals;
- the same with a further preference for the direction served last.

The precharge flag follows one of four page modes:
- never close the row;
- always close the row;
- two adaptive modes that look at the requests left in the bank after the selected one.

A parameter chooses between one shared buffer and separate read and write buffers of equal depth. Arrival age comes from an internal wrapping tag counter. Entries are compared by modular difference, so the ordering stays correct after the counter wraps.

Top module: `bank_sched`

## Requirements
- R1: After reset, out_valid is 0 and in_ready is 1 for either direction.
- R2: With SPLIT_RW=1, reads (in_we=0) and writes (in_we=1) each have DEPTH slots of their own. With SPLIT_RW=0 they share DEPTH slots. in_ready is 1 exactly when the buffer for in_we has a free slot. A full buffer refuses the push even if a pop happens in the same cycle.
- R3: An accepted push becomes eligible on the next cycle. out_valid is 1 exactly when an entry is held. A pop (out_valid and out_ready) removes the presented entry at that clock edge.
- R4: sched_mode 0 presents the oldest held entry.
- R5: sched_mode 1 presents the oldest entry whose row equals open_row while open_vld is 1. When no entry matches, or open_vld is 0, it presents the oldest entry.
- R6: sched_mode 2 first prefers entries whose direction equals that of the last popped entry (a read before any pop). Within that, it prefers open-row hits as in R5, then the oldest entry.
- R7: page_mode 0 keeps out_ap at 0.
- R8: page_mode 2 holds out_ap at 1 whenever out_valid is 1.
- R9: page_mode 1 sets out_ap only when at least one other entry is held and none of the other entries targets the presented row.
- R10: page_mode 3 sets out_ap when no other held entry targets the presented row, including when the presented entry is the only one.
- R11: Age ordering stays correct after more than 2^TAG_W pushes, while the live entries span fewer than 2^(TAG_W-1) arrivals.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sched_mode | input | 2 | Ordering mode: 0 arrival, 1 hit-first, 2 hit-first with direction grouping |
| page_mode | input | 2 | Precharge mode: 0 open, 1 open-adaptive, 2 closed, 3 closed-adaptive |
| open_vld | input | 1 | The bank has a row open |
| open_row | input | ROW_W | Row currently open in the bank |
| in_valid | input | 1 | Push request |
| in_ready | output | 1 | Target buffer has room |
| in_row | input | ROW_W | Row of pushed request |
| in_col | input | COL_W | Column of pushed request |
| in_we | input | 1 | Direction of pushed request, 1 = write |
| out_valid | output | 1 | An entry is presented |
| out_ready | input | 1 | Consumer takes the presented entry |
| out_row | output | ROW_W | Row of presented entry |
| out_col | output | COL_W | Column of presented entry |
| out_we | output | 1 | Direction of presented entry |
| out_ap | output | 1 | Presented access closes the row |

## Verification
A stale valid bit or a lost entry appears on the next cycle as a wrong out_valid or in_ready, or as an entry that was never pushed being presented. An age or priority fault is caught the first cycle two eligible entries disagree on ordering, since the bench compares every presented entry against its own queue. A wrong last-direction register shows only in grouping mode, on the first pop after a direction change. Precharge faults show at once on out_ap, and the adaptive cases are exercised with rows drawn from a small set so that row sharing is frequent.

// File: rtl/bank_sched.sv
module bank_sched #(
  parameter int DEPTH    = 8,
  parameter int ROW_W    = 14,
  parameter int COL_W    = 10,
  parameter int TAG_W    = 8,
  parameter bit SPLIT_RW = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       sched_mode,
  input  logic [1:0]       page_mode,
  input  logic             open_vld,
  input  logic [ROW_W-1:0] open_row,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [ROW_W-1:0] in_row,
  input  logic [COL_W-1:0] in_col,
  input  logic             in_we,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [ROW_W-1:0] out_row,
  output logic [COL_W-1:0] out_col,
  output logic             out_we,
  output logic             out_ap
);
  localparam int NSLOT = SPLIT_RW ? 2 * DEPTH : DEPTH;
  localparam int SW    = (NSLOT > 1) ? $clog2(NSLOT) : 1;

  logic [NSLOT-1:0] vld;
  logic [ROW_W-1:0] row_q [NSLOT];
  logic [COL_W-1:0] col_q [NSLOT];
  logic [NSLOT-1:0] we_q;
  logic [TAG_W-1:0] tag_q [NSLOT];
  logic [TAG_W-1:0] tag_ctr;
  logic             last_we;

  logic [NSLOT-1:0] hit;
  logic [1:0]       pri [NSLOT];
  logic [SW-1:0]    free_idx, sel;
  logic             free_ok, oth_any, oth_hit;
  logic             push, pop;

  always_comb begin
    free_ok  = 1'b0;
    free_idx = '0;
    for (int i = 0; i < NSLOT; i++) begin
      if (!vld[i] && !free_ok &&
          (!SPLIT_RW || (in_we ? (i >= DEPTH) : (i < DEPTH)))) begin
        free_ok  = 1'b1;
        free_idx = SW'(i);
      end
    end
  end

  always_comb begin
    for (int i = 0; i < NSLOT; i++) begin
      hit[i] = open_vld && (row_q[i] == open_row);
      pri[i] = {(sched_mode == 2'd2) && (we_q[i] == last_we),
                (sched_mode != 2'd0) && hit[i]};
    end
  end

  always_comb begin
    logic             found;
    logic [TAG_W-1:0] d;
    found = 1'b0;
    sel   = '0;
    for (int i = 0; i < NSLOT; i++) begin
      d = tag_q[i] - tag_q[sel];
      if (vld[i]) begin
        if (!found || (pri[i] > pri[sel]) || ((pri[i] == pri[sel]) && d[TAG_W-1])) begin
          sel   = SW'(i);
          found = 1'b1;
        end
      end
    end
  end

  always_comb begin
    oth_any = 1'b0;
    oth_hit = 1'b0;
    for (int i = 0; i < NSLOT; i++) begin
      if (vld[i] && (SW'(i) != sel)) begin
        oth_any = 1'b1;
        if (row_q[i] == row_q[sel]) oth_hit = 1'b1;
      end
    end
  end

  assign in_ready  = free_ok;
  assign out_valid = |vld;
  assign out_row   = row_q[sel];
  assign out_col   = col_q[sel];
  assign out_we    = we_q[sel];
  assign push      = in_valid && in_ready;
  assign pop       = out_valid && out_ready;

  always_comb begin
    case (page_mode)
      2'd0:    out_ap = 1'b0;
      2'd1:    out_ap = out_valid && oth_any && !oth_hit;
      2'd2:    out_ap = out_valid;
      default: out_ap = out_valid && !oth_hit;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld     <= '0;
      tag_ctr <= '0;
      last_we <= 1'b0;
    end else begin
      if (pop) begin
        vld[sel] <= 1'b0;
        last_we  <= we_q[sel];
      end
      if (push) begin
        vld[free_idx] <= 1'b1;
        tag_ctr       <= tag_ctr + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (push) begin
      row_q[free_idx] <= in_row;
      col_q[free_idx] <= in_col;
      we_q[free_idx]  <= in_we;
      tag_q[free_idx] <= tag_ctr;
    end
  end

  logic any_hit, dir_avail;
  always_comb begin
    any_hit   = 1'b0;
    dir_avail = 1'b0;
    for (int i = 0; i < NSLOT; i++) begin
      if (vld[i] && hit[i]) any_hit = 1'b1;
      if (vld[i] && (we_q[i] == last_we)) dir_avail = 1'b1;
    end
  end

  // R1
  ap_reset_empty_chk: assert property (@(posedge clk) $rose(rst_n) |-> !out_valid && in_ready);
  // R3
  push_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !pop) |=> ($countones(vld) == $past($countones(vld)) + 1));
  // R3
  pop_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !push) |=> ($countones(vld) + 1 == $past($countones(vld))));
  // R5
  hit_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sched_mode == 2'd1 && any_hit) |-> (out_row == open_row));
  // R6
  dir_group_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sched_mode == 2'd2 && dir_avail) |-> (out_we == last_we));
  // R7
  open_no_ap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (page_mode == 2'd0) |-> !out_ap);
  // R8
  closed_ap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (page_mode == 2'd2 && out_valid) |-> out_ap);
  // R9
  oa_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (page_mode == 2'd1 && $countones(vld) == 1) |-> !out_ap);
  // R10
  ca_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (page_mode == 2'd3 && $countones(vld) == 1) |-> out_ap);
endmodule

// File: tb/bank_sched_bench.sv
module bank_sched_bench;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 8;
  localparam int ROW_W = 14;
  localparam int COL_W = 10;
  localparam int NS    = 2 * DEPTH;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] sched_mode = 2'd0, page_mode = 2'd0;
  logic open_vld = 1'b0;
  logic [ROW_W-1:0] open_row = '0;
  logic in_valid = 1'b0, in_we = 1'b0, out_ready = 1'b0;
  logic [ROW_W-1:0] in_row = '0;
  logic [COL_W-1:0] in_col = '0;
  logic in_ready, out_valid, out_we, out_ap;
  logic [ROW_W-1:0] out_row;
  logic [COL_W-1:0] out_col;

  bank_sched #(.DEPTH(DEPTH), .ROW_W(ROW_W), .COL_W(COL_W), .TAG_W(8), .SPLIT_RW(1'b1)) u_bank_sched (
    .clk(clk), .rst_n(rst_n), .sched_mode(sched_mode), .page_mode(page_mode),
    .open_vld(open_vld), .open_row(open_row), .in_valid(in_valid), .in_ready(in_ready),
    .in_row(in_row), .in_col(in_col), .in_we(in_we), .out_valid(out_valid),
    .out_ready(out_ready), .out_row(out_row), .out_col(out_col), .out_we(out_we),
    .out_ap(out_ap));

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_chk = 0, n_fail = 0, cyc = 0, seq = 0;
  bit done = 1'b0;
  bit mv [NS];
  int mrow [NS], mcol [NS], mseq [NS];
  bit mwe [NS];
  bit mlast = 1'b0;

  task automatic chk(bit ok, string req, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic bit ref_room(bit we);
    int c = 0;
    for (int i = 0; i < NS; i++) if (mv[i] && mwe[i] == we) c++;
    return c < DEPTH;
  endfunction

  function automatic int ref_pri(int i);
    int p = 0;
    if (sched_mode == 2'd2 && mwe[i] == mlast) p += 2;
    if (sched_mode != 2'd0 && open_vld && mrow[i] == int'(open_row)) p += 1;
    return p;
  endfunction

  function automatic int ref_pick();
    int b = -1;
    for (int i = 0; i < NS; i++)
      if (mv[i] && (b < 0 || ref_pri(i) > ref_pri(b) ||
                    (ref_pri(i) == ref_pri(b) && mseq[i] < mseq[b]))) b = i;
    return b;
  endfunction

  function automatic bit ref_ap(int s);
    bit any = 0, sh = 0;
    for (int i = 0; i < NS; i++)
      if (mv[i] && i != s) begin
        any = 1;
        if (mrow[i] == mrow[s]) sh = 1;
      end
    case (page_mode)
      2'd0: return 1'b0;
      2'd1: return any && !sh;
      2'd2: return 1'b1;
      default: return !sh;
    endcase
  endfunction

  task automatic step(int push_pct, int pop_pct);
    int s;
    bit ex_rdy, do_push, do_pop;
    string sreq, areq;
    @(negedge clk);
    in_valid  = ($urandom_range(0, 99) < push_pct);
    in_we     = $urandom_range(0, 1);
    in_row    = ROW_W'($urandom_range(0, 3));
    in_col    = COL_W'(seq);
    out_ready = ($urandom_range(0, 99) < pop_pct);
    open_vld  = ($urandom_range(0, 9) < 8);
    open_row  = ROW_W'($urandom_range(0, 3));
    #1;
    ex_rdy = ref_room(in_we);
    chk(in_ready == ex_rdy, "R2", "in_ready", in_ready, ex_rdy);
    s = ref_pick();
    chk(out_valid == (s >= 0), "R3", "out_valid", out_valid, s >= 0);
    sreq = (sched_mode == 2'd0) ? "R4" : (sched_mode == 2'd1) ? "R5" : "R6";
    if (seq > 300) sreq = {sreq, " R11"};
    case (page_mode)
      2'd0: areq = "R7";
      2'd1: areq = "R9";
      2'd2: areq = "R8";
      default: areq = "R10";
    endcase
    if (s >= 0 && out_valid) begin
      chk(int'(out_col) == mcol[s] && int'(out_row) == mrow[s] && out_we == mwe[s],
          sreq, "selected col", int'(out_col), mcol[s]);
      chk(out_ap == ref_ap(s), areq, "out_ap", out_ap, ref_ap(s));
    end
    do_push = in_valid && ex_rdy;
    do_pop  = out_ready && (s >= 0);
    @(posedge clk);
    if (do_pop) begin
      mv[s] = 1'b0;
      mlast = mwe[s];
    end
    if (do_push) begin
      for (int i = 0; i < NS; i++)
        if (!mv[i]) begin
          mv[i] = 1'b1; mrow[i] = int'(in_row); mcol[i] = seq % 1024;
          mwe[i] = in_we; mseq[i] = seq;
          break;
        end
      seq++;
    end
  endtask

  initial begin
    void'($urandom(32'd7));
    for (int i = 0; i < NS; i++) mv[i] = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk(out_valid == 1'b0, "R1", "out_valid after reset", out_valid, 0);
    chk(in_ready == 1'b1, "R1", "in_ready after reset", in_ready, 1);
    for (int sm = 0; sm < 3; sm++)
      for (int pm = 0; pm < 4; pm++) begin
        sched_mode = 2'(sm);
        page_mode  = 2'(pm);
        for (int k = 0; k < 6; k++)
          for (int c = 0; c < 40; c++)
            step((k % 2 == 0) ? 85 : 25, (k % 2 == 0) ? 25 : 80);
      end
    for (int c = 0; c < 80; c++) step(0, 100);
    done = 1'b1;
    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000 && !done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired actual=%0d expected=0", cyc);
      $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule